// File: doc/BRIEF.md
# Coprocessor Access Bridge

This block links a processor's command port to a set of reconfigurable coprocessor areas. The processor issues one of four operations: select a coprocessor by identifier, pulse the reset of a named coprocessor, write a command word and a data word to the selected coprocessor, or write one word and then read one word back from it. Each area has its own copy of the bus signals: chip enable, read/write, reset, address, data out, data in and acknowledge. The bridge drives only the copy that belongs to the target area and keeps the others idle.

The bridge learns where coprocessors live from a residency input. Each area reports a valid bit and the identifier of the coprocessor currently loaded in it. The bridge keeps the most recent selection. When a data operation starts, it sends that operation to the area that holds the selected identifier. If no area holds that identifier, or if nothing has been selected yet, the bridge returns an error flag and drives nothing on the bus. The processor is held off through a ready signal for as long as a transfer is in progress. The word read back is returned with a single-cycle valid strobe.

Top module: `copro_bridge`

## Requirements
- R1: After reset, cmd_ready is 1, rd_valid and op_err are 0, every area line (ce, rw, rst, addr, dout) is 0, and no coprocessor is selected.
- R2: Op code 0 (select) is taken in one cycle and records cmd_id as the selection. cmd_ready stays 1 and no area line moves.
- R3: Op code 2 (write pair) runs two write phases (rw=0) on the routed area. The first phase has addr 0 and dout=cmd_a. The second has addr 1 and dout=cmd_b.
- R4: Op code 3 (write-then-read) runs a write phase (addr 0, dout=cmd_a, rw=0) and then a read phase (addr 1, rw=1, dout 0). The routed area's data-in is captured in the cycle its acknowledge is seen. That word appears on rd_data with rd_valid high for exactly the next cycle.
- R5: In every phase, ce stays high until the routed area's acknowledge is seen, then falls. The next phase, or the return to ready, waits until that acknowledge is low.
- R6: A data operation goes to the area whose valid residency entry matches the latest selection at the moment the operation is accepted. If several areas match, the lowest-numbered one wins. Other areas stay idle, and their acknowledges have no effect.
- R7: Op code 1 (reset) runs one phase on the area holding cmd_id, with ce and rst high and addr and dout at 0. If no area holds cmd_id, op_err pulses for one cycle and no area line moves.
- R8: A write pair or write-then-read with no selection, or with a selected identifier that no area holds, pulses op_err for one cycle, drives no area line, and leaves cmd_ready at 1.
- R9: cmd_ready falls in the cycle after a bus operation is accepted and rises once the final phase's acknowledge has dropped. cmd_valid is ignored while cmd_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Operation request |
| cmd_op | input | 2 | 0 select, 1 reset, 2 write pair, 3 write-then-read |
| cmd_id | input | ID_W | Coprocessor identifier for select and reset |
| cmd_a | input | DATA_W | First word (command or address) |
| cmd_b | input | DATA_W | Second word for write pair |
| cmd_ready | output | 1 | Bridge idle, request taken when valid |
| rd_valid | output | 1 | One-cycle strobe for returned word |
| rd_data | output | DATA_W | Word read back |
| op_err | output | 1 | One-cycle strobe for a rejected operation |
| res_valid | input | NUM_AREAS | Area holds a loaded coprocessor |
| res_id | input | NUM_AREAS*ID_W | Identifier loaded in each area |
| area_ce | output | NUM_AREAS | Chip enable per area |
| area_rw | output | NUM_AREAS | 1 for read phase per area |
| area_rst | output | NUM_AREAS | Coprocessor reset per area |
| area_addr | output | NUM_AREAS*ADDR_W | Phase address per area |
| area_dout | output | NUM_AREAS*DATA_W | Write data per area |
| area_ack | input | NUM_AREAS | Acknowledge per area |
| area_din | input | NUM_AREAS*DATA_W | Read data per area |

## Verification
Back-to-back operations are issued while the bridge is still busy. This separates correct hold-off from lost or double-accepted requests. Areas answer with different acknowledge delays, and the data-in they return changes every cycle, so a read captured one cycle early or late shows up as a wrong word. A stray acknowledge held on an idle area tells correct routing apart from a bridge that reacts to any acknowledge. The residency table is also changed between selecting and using an identifier, so that binding the target when the operation starts can be told apart from binding it at selection time. Reset and data operations aimed at identifiers that are not loaded check the error path.

// File: rtl/copro_pkg.sv
package copro_pkg;

   typedef enum logic [1:0] {
      OP_SELECT = 2'd0,
      OP_RESET  = 2'd1,
      OP_WPAIR  = 2'd2,
      OP_WREAD  = 2'd3
   } copro_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_REL  = 2'd2
   } xfer_st_e;

endpackage

// File: rtl/copro_area_lookup.sv
module copro_area_lookup #(
   parameter int NUM_AREAS = 3,
   parameter int ID_W      = 4,
   parameter int IDX_W     = 2
) (
   input  logic [NUM_AREAS-1:0]      res_valid,
   input  logic [NUM_AREAS*ID_W-1:0] res_id,
   input  logic [ID_W-1:0]           query,
   output logic                      hit,
   output logic [IDX_W-1:0]          idx
);
   // lowest-numbered matching area wins: scan downward, last match kept
   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int k = NUM_AREAS - 1; k >= 0; k--) begin
         if (res_valid[k] && (res_id[k*ID_W +: ID_W] == query)) begin
            hit = 1'b1;
            idx = IDX_W'(k);
         end
      end
   end
endmodule

// File: rtl/copro_phase_fsm.sv
module copro_phase_fsm
   import copro_pkg::*;
#(
   parameter int ID_W   = 4,
   parameter int DATA_W = 16,
   parameter int ADDR_W = 2,
   parameter int IDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [ID_W-1:0]   cmd_id,
   input  logic [DATA_W-1:0] cmd_a,
   input  logic [DATA_W-1:0] cmd_b,
   output logic              cmd_ready,
   input  logic              rst_hit,
   input  logic [IDX_W-1:0]  rst_idx,
   input  logic              sel_hit,
   input  logic [IDX_W-1:0]  sel_idx,
   output logic [ID_W-1:0]   sel_id,
   input  logic              ack_t,
   input  logic [DATA_W-1:0] din_t,
   output logic [IDX_W-1:0]  route,
   output logic              bus_ce,
   output logic              bus_rw,
   output logic              bus_rst,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_dout,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              op_err
);
   xfer_st_e          st;
   copro_op_e         op_q;
   copro_op_e         op_in;
   logic              phase;
   logic              sel_ok;
   logic [DATA_W-1:0] a_q;
   logic [DATA_W-1:0] b_q;

   assign op_in = copro_op_e'(cmd_op);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         op_q     <= OP_SELECT;
         phase    <= 1'b0;
         sel_ok   <= 1'b0;
         sel_id   <= '0;
         route    <= '0;
         a_q      <= '0;
         b_q      <= '0;
         rd_data  <= '0;
         rd_valid <= 1'b0;
         op_err   <= 1'b0;
      end else begin
         rd_valid <= 1'b0;
         op_err   <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (cmd_valid) begin
                  op_q  <= op_in;
                  a_q   <= cmd_a;
                  b_q   <= cmd_b;
                  phase <= 1'b0;
                  unique case (op_in)
                     OP_SELECT: begin
                        sel_id <= cmd_id;
                        sel_ok <= 1'b1;
                     end
                     OP_RESET: begin
                        if (rst_hit) begin
                           route <= rst_idx;
                           st    <= ST_REQ;
                        end else begin
                           op_err <= 1'b1;
                        end
                     end
                     default: begin
                        if (sel_ok && sel_hit) begin
                           route <= sel_idx;
                           st    <= ST_REQ;
                        end else begin
                           op_err <= 1'b1;
                        end
                     end
                  endcase
               end
            end
            ST_REQ: begin
               if (ack_t) begin
                  if (op_q == OP_WREAD && phase) begin
                     rd_data  <= din_t;
                     rd_valid <= 1'b1;
                  end
                  st <= ST_REL;
               end
            end
            ST_REL: begin
               if (!ack_t) begin
                  if (op_q == OP_RESET || phase) begin
                     st <= ST_IDLE;
                  end else begin
                     phase <= 1'b1;
                     st    <= ST_REQ;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign cmd_ready = (st == ST_IDLE);
   assign bus_ce    = (st == ST_REQ);
   assign bus_rw    = bus_ce && (op_q == OP_WREAD) && phase;
   assign bus_rst   = bus_ce && (op_q == OP_RESET);

   always_comb begin
      bus_dout = '0;
      if (bus_ce && op_q != OP_RESET) begin
         if (!phase)                bus_dout = a_q;
         else if (op_q == OP_WPAIR) bus_dout = b_q;
      end
   end

   generate
      if (ADDR_W == 1) begin : g_addr_narrow
         assign bus_addr = bus_ce ? phase : 1'b0;
      end else begin : g_addr_wide
         assign bus_addr = bus_ce ? {{(ADDR_W-1){1'b0}}, phase} : '0;
      end
   endgenerate
endmodule

// File: rtl/copro_area_mux.sv
module copro_area_mux #(
   parameter int NUM_AREAS = 3,
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 2,
   parameter int IDX_W     = 2
) (
   input  logic [IDX_W-1:0]            route,
   input  logic                        bus_ce,
   input  logic                        bus_rw,
   input  logic                        bus_rst,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic [DATA_W-1:0]           bus_dout,
   output logic                        ack_t,
   output logic [DATA_W-1:0]           din_t,
   input  logic [NUM_AREAS-1:0]        area_ack,
   input  logic [NUM_AREAS*DATA_W-1:0] area_din,
   output logic [NUM_AREAS-1:0]        area_ce,
   output logic [NUM_AREAS-1:0]        area_rw,
   output logic [NUM_AREAS-1:0]        area_rst,
   output logic [NUM_AREAS*ADDR_W-1:0] area_addr,
   output logic [NUM_AREAS*DATA_W-1:0] area_dout
);
   generate
      for (genvar k = 0; k < NUM_AREAS; k++) begin : g_area
         logic sel_k;
         assign sel_k       = bus_ce && (route == IDX_W'(k));
         assign area_ce[k]  = sel_k;
         assign area_rw[k]  = sel_k && bus_rw;
         assign area_rst[k] = sel_k && bus_rst;
         assign area_addr[k*ADDR_W +: ADDR_W] = sel_k ? bus_addr : '0;
         assign area_dout[k*DATA_W +: DATA_W] = sel_k ? bus_dout : '0;
      end
   endgenerate

   always_comb begin
      ack_t = 1'b0;
      din_t = '0;
      for (int k = 0; k < NUM_AREAS; k++) begin
         if (route == IDX_W'(k)) begin
            ack_t = area_ack[k];
            din_t = area_din[k*DATA_W +: DATA_W];
         end
      end
   end
endmodule

// File: rtl/copro_bridge.sv
module copro_bridge
   import copro_pkg::*;
#(
   parameter int NUM_AREAS = 3,
   parameter int ID_W      = 4,
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cmd_valid,
   input  logic [1:0]                  cmd_op,
   input  logic [ID_W-1:0]             cmd_id,
   input  logic [DATA_W-1:0]           cmd_a,
   input  logic [DATA_W-1:0]           cmd_b,
   output logic                        cmd_ready,
   output logic                        rd_valid,
   output logic [DATA_W-1:0]           rd_data,
   output logic                        op_err,
   input  logic [NUM_AREAS-1:0]        res_valid,
   input  logic [NUM_AREAS*ID_W-1:0]   res_id,
   output logic [NUM_AREAS-1:0]        area_ce,
   output logic [NUM_AREAS-1:0]        area_rw,
   output logic [NUM_AREAS-1:0]        area_rst,
   output logic [NUM_AREAS*ADDR_W-1:0] area_addr,
   output logic [NUM_AREAS*DATA_W-1:0] area_dout,
   input  logic [NUM_AREAS-1:0]        area_ack,
   input  logic [NUM_AREAS*DATA_W-1:0] area_din
);
   localparam int IDX_W = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1;

   generate
      if (NUM_AREAS < 1 || NUM_AREAS > 64) begin : g_bad_areas
         $error("copro_bridge: NUM_AREAS must be 1..64");
      end
      if (ID_W < 1) begin : g_bad_id
         $error("copro_bridge: ID_W must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("copro_bridge: DATA_W must be at least 1");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("copro_bridge: ADDR_W must be at least 1");
      end
   endgenerate

   logic              rst_hit, sel_hit;
   logic [IDX_W-1:0]  rst_idx, sel_idx, route;
   logic [ID_W-1:0]   sel_id;
   logic              ack_t;
   logic [DATA_W-1:0] din_t;
   logic              bus_ce, bus_rw, bus_rst;
   logic [ADDR_W-1:0] bus_addr;
   logic [DATA_W-1:0] bus_dout;

   copro_area_lookup #(.NUM_AREAS(NUM_AREAS), .ID_W(ID_W), .IDX_W(IDX_W)) u_rst_lookup (
      .res_valid (res_valid),
      .res_id    (res_id),
      .query     (cmd_id),
      .hit       (rst_hit),
      .idx       (rst_idx)
   );

   copro_area_lookup #(.NUM_AREAS(NUM_AREAS), .ID_W(ID_W), .IDX_W(IDX_W)) u_sel_lookup (
      .res_valid (res_valid),
      .res_id    (res_id),
      .query     (sel_id),
      .hit       (sel_hit),
      .idx       (sel_idx)
   );

   copro_phase_fsm #(.ID_W(ID_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_id    (cmd_id),
      .cmd_a     (cmd_a),
      .cmd_b     (cmd_b),
      .cmd_ready (cmd_ready),
      .rst_hit   (rst_hit),
      .rst_idx   (rst_idx),
      .sel_hit   (sel_hit),
      .sel_idx   (sel_idx),
      .sel_id    (sel_id),
      .ack_t     (ack_t),
      .din_t     (din_t),
      .route     (route),
      .bus_ce    (bus_ce),
      .bus_rw    (bus_rw),
      .bus_rst   (bus_rst),
      .bus_addr  (bus_addr),
      .bus_dout  (bus_dout),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data),
      .op_err    (op_err)
   );

   copro_area_mux #(.NUM_AREAS(NUM_AREAS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_mux (
      .route     (route),
      .bus_ce    (bus_ce),
      .bus_rw    (bus_rw),
      .bus_rst   (bus_rst),
      .bus_addr  (bus_addr),
      .bus_dout  (bus_dout),
      .ack_t     (ack_t),
      .din_t     (din_t),
      .area_ack  (area_ack),
      .area_din  (area_din),
      .area_ce   (area_ce),
      .area_rw   (area_rw),
      .area_rst  (area_rst),
      .area_addr (area_addr),
      .area_dout (area_dout)
   );
endmodule

// File: rtl/copro_bridge_chk.sv
module copro_bridge_chk #(
   parameter int NUM_AREAS = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cmd_ready,
   input logic                 rd_valid,
   input logic                 op_err,
   input logic [NUM_AREAS-1:0] area_ce,
   input logic [NUM_AREAS-1:0] area_rst,
   input logic [NUM_AREAS-1:0] area_ack
);
   // R6: at most one area addressed at a time
   p_one_area_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(area_ce));

   // R9: processor held off while any phase is on the bus
   p_busy_on_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|area_ce) |-> !cmd_ready);

   // R4: returned word strobe lasts one cycle
   p_rdv_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   // R8: rejected operation leaves the bus quiet
   p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      op_err |-> (area_ce == '0));

   generate
      for (genvar k = 0; k < NUM_AREAS; k++) begin : g_per_area
         // R5: enable held until acknowledged
         p_hold_ce_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (area_ce[k] && !area_ack[k]) |=> area_ce[k]);
         // R7: reset line only rides on an active phase
         p_rst_in_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
            area_rst[k] |-> area_ce[k]);
      end
   endgenerate
endmodule

bind copro_bridge copro_bridge_chk #(.NUM_AREAS(NUM_AREAS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_ready (cmd_ready),
   .rd_valid  (rd_valid),
   .op_err    (op_err),
   .area_ce   (area_ce),
   .area_rst  (area_rst),
   .area_ack  (area_ack)
);

// File: tb/copro_bridge_bench.sv
module copro_bridge_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NA  = 3;
   localparam int IDW = 4;
   localparam int DW  = 16;
   localparam int AW  = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_valid = 1'b0;
   logic [1:0]        cmd_op = '0;
   logic [IDW-1:0]    cmd_id = '0;
   logic [DW-1:0]     cmd_a = '0;
   logic [DW-1:0]     cmd_b = '0;
   logic              cmd_ready;
   logic              rd_valid;
   logic [DW-1:0]     rd_data;
   logic              op_err;
   logic [NA-1:0]     res_valid = '0;
   logic [NA*IDW-1:0] res_id = '0;
   logic [NA-1:0]     area_ce, area_rw, area_rst;
   logic [NA*AW-1:0]  area_addr;
   logic [NA*DW-1:0]  area_dout;
   logic [NA-1:0]     area_ack = '0;
   logic [NA*DW-1:0]  area_din = '0;

   copro_bridge #(.NUM_AREAS(NA), .ID_W(IDW), .DATA_W(DW), .ADDR_W(AW)) u_copro_bridge (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_id(cmd_id),
      .cmd_a(cmd_a), .cmd_b(cmd_b), .cmd_ready(cmd_ready), .rd_valid(rd_valid),
      .rd_data(rd_data), .op_err(op_err), .res_valid(res_valid), .res_id(res_id),
      .area_ce(area_ce), .area_rw(area_rw), .area_rst(area_rst), .area_addr(area_addr),
      .area_dout(area_dout), .area_ack(area_ack), .area_din(area_din)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // ---------------- reference model (behavioural) ----------------
   int            m_st = 0;      // 0 idle, 1 request, 2 release
   int            m_op = 0;
   int            m_ph = 0;
   int            m_route = 0;
   bit            m_selok = 0;
   logic [IDW-1:0] m_sel = '0;
   logic [DW-1:0] m_a = '0, m_b = '0, m_rdd = '0;
   bit            m_rdv = 0, m_err = 0;

   function automatic int find_area(input logic [IDW-1:0] id);
      for (int k = 0; k < NA; k++)
         if (res_valid[k] && res_id[k*IDW +: IDW] == id) return k;
      return -1;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_op = 0; m_ph = 0; m_route = 0; m_selok = 0; m_sel = '0;
         m_a = '0; m_b = '0; m_rdd = '0; m_rdv = 0; m_err = 0;
      end else begin
         int f;
         bit a_t;
         logic [DW-1:0] d_t;
         a_t = area_ack[m_route];
         d_t = area_din[m_route*DW +: DW];
         m_rdv = 0;
         m_err = 0;
         if (m_st == 0) begin
            if (cmd_valid) begin
               if (cmd_op == 2'd0) begin
                  m_sel = cmd_id; m_selok = 1;
               end else begin
                  f = (cmd_op == 2'd1) ? find_area(cmd_id) : (m_selok ? find_area(m_sel) : -1);
                  if (f < 0) m_err = 1;
                  else begin
                     m_route = f; m_op = cmd_op; m_ph = 0; m_a = cmd_a; m_b = cmd_b; m_st = 1;
                  end
               end
            end
         end else if (m_st == 1) begin
            if (a_t) begin
               if (m_op == 3 && m_ph == 1) begin m_rdd = d_t; m_rdv = 1; end
               m_st = 2;
            end
         end else begin
            if (!a_t) begin
               if (m_op == 1 || m_ph == 1) m_st = 0;
               else begin m_ph = 1; m_st = 1; end
            end
         end
      end
   end

   // ---------------- compare, responders, watchdog ----------------
   int            lat [NA] = '{2, 1, 3};
   int            cnt [NA] = '{0, 0, 0};
   logic [NA-1:0] stray = '0;
   logic [NA-1:0] ack_r = '0;
   int            tick = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         logic [NA-1:0]    e_ce, e_rw, e_rst;
         logic [NA*AW-1:0] e_addr;
         logic [NA*DW-1:0] e_dout;
         e_ce = '0; e_rw = '0; e_rst = '0; e_addr = '0; e_dout = '0;
         if (m_st == 1) begin
            e_ce[m_route]  = 1'b1;
            e_rw[m_route]  = (m_op == 3 && m_ph == 1);
            e_rst[m_route] = (m_op == 1);
            e_addr[m_route*AW +: AW] = AW'(m_ph);
            if (m_op != 1) begin
               if (m_ph == 0)      e_dout[m_route*DW +: DW] = m_a;
               else if (m_op == 2) e_dout[m_route*DW +: DW] = m_b;
            end
         end
         chk("R9", "cmd_ready", cmd_ready, (m_st == 0));
         chk("R5", "area_ce", area_ce, e_ce);
         chk("R4", "area_rw", area_rw, e_rw);
         chk("R7", "area_rst", area_rst, e_rst);
         chk("R3", "area_addr", area_addr, e_addr);
         chk("R3", "area_dout", area_dout, e_dout);
         chk("R4", "rd_valid", rd_valid, m_rdv);
         chk("R4", "rd_data", rd_data, m_rdd);
         chk("R8", "op_err", op_err, m_err);
      end
      for (int k = 0; k < NA; k++) begin
         if (area_ce[k]) begin
            cnt[k]++;
            ack_r[k] = (cnt[k] >= lat[k]);
         end else begin
            cnt[k] = 0;
            ack_r[k] = 1'b0;
         end
         area_din[k*DW +: DW] = 16'(16'hA000 + k * 16'h0100 + tick);
      end
      area_ack = ack_r | stray;
      tick++;
      cyc++;
      if (cyc > 20000) begin
         errors++;
         $display("FAIL R9 watchdog actual hung expected idle");
         report();
      end
   end

   // ---------------- stimulus ----------------
   task automatic issue(input logic [1:0] op, input logic [IDW-1:0] id,
                        input logic [DW-1:0] a, input logic [DW-1:0] b);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_id = id; cmd_a = a; cmd_b = b;
      while (!cmd_ready) @(negedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_idle();
      repeat (2) @(negedge clk);
      while (!cmd_ready) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "ready in reset", cmd_ready, 1);
      chk("R1", "ce in reset", area_ce, 0);
      chk("R1", "rst in reset", area_rst, 0);
      chk("R1", "rd_valid in reset", rd_valid, 0);
      chk("R1", "err in reset", op_err, 0);
      rst_n = 1'b1;

      // R8: data op before any selection
      issue(2'd2, 4'd0, 16'h1111, 16'h2222);
      chk("R8", "err without selection", op_err, 1);

      res_id = {4'd3, 4'd9, 4'd5};
      res_valid = 3'b111;

      // R2: select
      issue(2'd0, 4'd9, 16'h0, 16'h0);
      chk("R2", "ready after select", cmd_ready, 1);
      chk("R2", "bus idle after select", area_ce, 0);

      // R3, R4, R6 to area 1, back to back
      issue(2'd2, 4'd0, 16'h1234, 16'h5678);
      issue(2'd3, 4'd0, 16'h00C3, 16'h0);
      wait_idle();

      // R6: stray acknowledge on an idle area
      issue(2'd0, 4'd3, 16'h0, 16'h0);
      stray = 3'b001;
      issue(2'd3, 4'd0, 16'h0A0A, 16'h0);
      issue(2'd2, 4'd0, 16'hBEEF, 16'hCAFE);
      wait_idle();
      chk("R6", "area0 untouched under stray ack", area_ce[0], 0);
      stray = '0;

      // R7: reset resident and absent identifiers
      issue(2'd1, 4'd5, 16'h7777, 16'h0);
      issue(2'd1, 4'd12, 16'h0, 16'h0);
      chk("R7", "err on absent reset", op_err, 1);
      chk("R7", "no area touched", area_ce, 0);

      // R8 then R6: selection of a not-yet-loaded id, later loaded in area 0
      issue(2'd0, 4'd7, 16'h0, 16'h0);
      issue(2'd2, 4'd0, 16'h3333, 16'h4444);
      chk("R8", "err on absent selection", op_err, 1);
      @(negedge clk);
      res_id[0 +: IDW] = 4'd7;
      issue(2'd3, 4'd0, 16'h0055, 16'h0);
      wait_idle();

      // R6: duplicate residency, lowest area wins
      res_id[2*IDW +: IDW] = 4'd7;
      lat = '{1, 1, 1};
      issue(2'd2, 4'd0, 16'h0F0F, 16'hF0F0);
      issue(2'd3, 4'd0, 16'h00AA, 16'h0);
      wait_idle();

      // R8: area dropped out after selection
      issue(2'd0, 4'd9, 16'h0, 16'h0);
      @(negedge clk);
      res_valid[1] = 1'b0;
      issue(2'd3, 4'd0, 16'h1357, 16'h0);
      chk("R8", "err after area unloaded", op_err, 1);
      chk("R8", "ready stays high", cmd_ready, 1);

      // R9: busy hold-off with long latency
      lat = '{4, 4, 4};
      issue(2'd0, 4'd3, 16'h0, 16'h0);
      issue(2'd2, 4'd0, 16'h2468, 16'h8642);
      issue(2'd1, 4'd3, 16'h0, 16'h0);
      issue(2'd3, 4'd0, 16'h0101, 16'h0);
      wait_idle();
      repeat (3) @(negedge clk);
      report();
   end
endmodule